// File: doc/BRIEF.md
# Data Move Execution Unit

This block carries out the data move operations of a 16-bit signal processor core. It accepts one pre-decoded move at a time and handles register to register copies, long and short immediate loads, and loads and stores to data memory. Memory moves use either register-indirect addressing with an optional pointer update or direct addressing, where the address is formed from a base register and a 5-bit offset. The block holds the registers that moves can reach. Narrow registers are extended when read, and a write-only control register reads back as zero.

Each move takes a number of cycles that depends on its kind, on the programmed wait-state count when program or data traffic goes to external memory, and on a bank conflict between the program counter and the data address in internal memory. When the move retires, the block raises a one-cycle done strobe and reports the cycle count, the number of program words the move used, and any illegal-request or illegal-read condition. Data memory sits on one combinational-read port that the block drives only in the retiring cycle.

Top module: `dmove_unit`

## Requirements
- R1: A legal register copy, long immediate load, memory load or memory store retires with `done_o` high in the 2nd cycle after it is accepted, and `cycles_o` reads 2, when no wait-state or bank penalty applies. `done_o` is high for one cycle per move. `req_ready_o` is low from acceptance until retirement.
- R2: If `pc_ext_i` is set, or a memory move targets an external address (address bits [15:14] both 1), then `wait_cnt_i` cycles are added once to the total.
- R3: If a memory move targets an internal address, `pc_ext_i` is clear, and `pc_bank_i` equals address bits [11:10], then one cycle is added.
- R4: `words_o` reads 2 for a long immediate load (op 1) and 1 for every other op. The op codes are: 0 copy, 1 long immediate, 2 short immediate, 3 indirect load, 4 indirect store, 5 direct load, 6 direct store.
- R5: A short immediate load (op 2) writes `req_imm_i[8:0]`, zero-extended, into an address register (selectors 0 to 3 are pointers ptr0 to ptr3, selector 4 is step register stepj) and retires in one cycle plus any R2 penalty.
- R6: Two requests are illegal: a long immediate load with `req_cache_i` set, and a short immediate load to a selector above 4. An illegal request retires after one cycle with `illegal_o` high, changes no register and makes no memory access.
- R7: Direct moves use the address {base[15:5], `req_imm_i[4:0]`}, where base is selector 5.
- R8: Indirect moves use the pointer chosen by `req_ptr_i` as the address. After the access, that pointer is updated according to `req_pmod_i`: 0 leaves it unchanged, 1 adds 1, 2 subtracts 1, 3 adds stepj.
- R9: Selector 6 is an 8-bit signed register and is sign-extended to 16 bits when read. Selector 7 is a 6-bit unsigned register and is zero-extended when read. Selectors 8 (write-only control) and 9 (accumulator high) are 16 bits wide.
- R10: Reading selector 8 through a copy or a store returns zero and raises `bad_read_o` during the retiring cycle.
- R11: `mem_req_o` is high only in the retiring cycle of a legal memory move, with `mem_we_o` high for stores. Load data is taken from `mem_rdata_i` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Move request present |
| req_ready_o | output | 1 | Unit idle; request accepted when valid |
| req_op_i | input | 3 | Move kind |
| req_dst_i | input | 4 | Destination register selector |
| req_src_i | input | 4 | Source register selector |
| req_imm_i | input | 16 | Immediate value or direct offset |
| req_ptr_i | input | 2 | Pointer selector for indirect moves |
| req_pmod_i | input | 2 | Pointer post-update mode |
| req_cache_i | input | 1 | Move issued from instruction cache |
| pc_ext_i | input | 1 | Program counter in external memory |
| pc_bank_i | input | 2 | Internal bank of program counter |
| wait_cnt_i | input | 4 | Programmed wait-state count |
| mem_req_o | output | 1 | Data memory access strobe |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_o | output | 16 | Data memory address |
| mem_wdata_o | output | 16 | Data memory write data |
| mem_rdata_i | input | 16 | Data memory read data (combinational) |
| done_o | output | 1 | Move retires this cycle |
| cycles_o | output | 6 | Cycles used by the retiring move |
| words_o | output | 2 | Program words used by the retiring move |
| illegal_o | output | 1 | Retiring request was illegal |
| bad_read_o | output | 1 | Write-only register was read |

## Verification
The assertions are checked on every cycle. They cover the single-cycle done pulse, the busy window after acceptance, the rule that memory is accessed only in the retiring cycle and never for an illegal request, zero write data on a write-only read, and single-cycle retirement of short immediates from internal program memory. Some behaviour can only be shown by the bench scenarios, which compare the unit against a behavioural model: the exact penalty totals, direct and post-updated indirect addresses, sign and zero extension of narrow registers, and the registers left unchanged after illegal requests. The bench observes these through later stores.

// File: rtl/dmove_pkg.sv
package dmove_pkg;
    localparam int AW   = 16;
    localparam int NREG = 10;
    localparam int NS_W = 8;
    localparam int NU_W = 6;

    typedef enum logic [2:0] {
        OP_RR     = 3'd0,
        OP_LIMM   = 3'd1,
        OP_SIMM   = 3'd2,
        OP_LD_IND = 3'd3,
        OP_ST_IND = 3'd4,
        OP_LD_DIR = 3'd5,
        OP_ST_DIR = 3'd6,
        OP_RSVD   = 3'd7
    } mv_op_e;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_INC  = 2'd1,
        PM_DEC  = 2'd2,
        PM_ADDJ = 2'd3
    } pmod_e;

    localparam logic [3:0] SEL_STEPJ = 4'd4;
    localparam logic [3:0] SEL_BASE  = 4'd5;
    localparam logic [3:0] SEL_NS    = 4'd6;
    localparam logic [3:0] SEL_NU    = 4'd7;
    localparam logic [3:0] SEL_WO    = 4'd8;
endpackage

// File: rtl/dmove_agen.sv
module dmove_agen
    import dmove_pkg::*;
#(
    parameter int OFF_W = 5
) (
    input  mv_op_e                 op,
    input  logic [OFF_W-1:0]       offset,
    input  logic [AW-1:OFF_W]      base_hi,
    input  logic [AW-1:0]          ptr_val,
    input  logic [AW-1:0]          stepj,
    input  logic [1:0]             pmod,
    output logic [AW-1:0]          addr,
    output logic [AW-1:0]          ptr_next
);
    logic direct;

    always_comb begin
        direct = (op == OP_LD_DIR) || (op == OP_ST_DIR);
        addr   = direct ? {base_hi, offset} : ptr_val;
        case (pmod_e'(pmod))
            PM_INC:  ptr_next = ptr_val + 1'b1;
            PM_DEC:  ptr_next = ptr_val - 1'b1;
            PM_ADDJ: ptr_next = ptr_val + stepj;
            default: ptr_next = ptr_val;
        endcase
    end
endmodule

// File: rtl/dmove_cost.sv
module dmove_cost
    import dmove_pkg::*;
#(
    parameter int WAIT_W = 4,
    parameter int BANK_W = 2,
    parameter int EXT_W  = 2,
    parameter int CNT_W  = WAIT_W + 2
) (
    input  mv_op_e             op,
    input  logic [3:0]         dst,
    input  logic               from_cache,
    input  logic               pc_ext,
    input  logic [BANK_W-1:0]  pc_bank,
    input  logic [WAIT_W-1:0]  waits,
    input  logic [EXT_W-1:0]   addr_top,
    input  logic [BANK_W-1:0]  addr_bank,
    output logic [CNT_W-1:0]   total,
    output logic [1:0]         words,
    output logic               illegal
);
    logic is_mem, data_ext;

    always_comb begin
        is_mem   = (op == OP_LD_IND) || (op == OP_ST_IND) ||
                   (op == OP_LD_DIR) || (op == OP_ST_DIR);
        data_ext = is_mem && (addr_top == {EXT_W{1'b1}});
        illegal  = ((op == OP_LIMM) && from_cache) ||
                   ((op == OP_SIMM) && (dst > SEL_STEPJ)) ||
                   (op == OP_RSVD);
        words    = (op == OP_LIMM) ? 2'd2 : 2'd1;
        total    = (op == OP_SIMM) ? CNT_W'(1) : CNT_W'(2);
        if (pc_ext || data_ext)
            total = total + CNT_W'(waits);
        if (is_mem && !pc_ext && !data_ext && (addr_bank == pc_bank))
            total = total + CNT_W'(1);
        if (illegal)
            total = CNT_W'(1);
    end
endmodule

// File: rtl/dmove_unit.sv
module dmove_unit
    import dmove_pkg::*;
#(
    parameter int WAIT_W   = 4,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 10,
    parameter int EXT_W    = 2,
    parameter int OFF_W    = 5,
    localparam int CNT_W   = WAIT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [2:0]         req_op_i,
    input  logic [3:0]         req_dst_i,
    input  logic [3:0]         req_src_i,
    input  logic [15:0]        req_imm_i,
    input  logic [1:0]         req_ptr_i,
    input  logic [1:0]         req_pmod_i,
    input  logic               req_cache_i,
    input  logic               pc_ext_i,
    input  logic [BANK_W-1:0]  pc_bank_i,
    input  logic [WAIT_W-1:0]  wait_cnt_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [15:0]        mem_addr_o,
    output logic [15:0]        mem_wdata_o,
    input  logic [15:0]        mem_rdata_i,
    output logic               done_o,
    output logic [CNT_W-1:0]   cycles_o,
    output logic [1:0]         words_o,
    output logic               illegal_o,
    output logic               bad_read_o
);
    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [CNT_W-1:0]           total;
        logic [1:0]                 words;
        logic                       illegal;
        mv_op_e                     op;
        logic [3:0]                 dst;
        logic [3:0]                 src;
        logic [1:0]                 ptr;
        logic [1:0]                 pmod;
        logic [AW-1:0]              imm;
        logic [NREG-1:0][AW-1:0]    rf;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [AW-1:0] rd_ext(input logic [NREG-1:0][AW-1:0] rf,
                                             input logic [3:0] sel);
        logic [AW-1:0] v;
        v = (int'(sel) < NREG) ? rf[sel] : '0;
        case (sel)
            SEL_NS:  return {{(AW-NS_W){v[NS_W-1]}}, v[NS_W-1:0]};
            SEL_NU:  return {{(AW-NU_W){1'b0}}, v[NU_W-1:0]};
            SEL_WO:  return '0;
            default: return v;
        endcase
    endfunction

    function automatic logic [AW-1:0] wr_fmt(input logic [3:0] sel, input logic [AW-1:0] v);
        case (sel)
            SEL_NS:  return {{(AW-NS_W){1'b0}}, v[NS_W-1:0]};
            SEL_NU:  return {{(AW-NU_W){1'b0}}, v[NU_W-1:0]};
            default: return v;
        endcase
    endfunction

    mv_op_e            req_op;
    logic [AW-1:0]     req_addr, req_pnext, exe_addr, exe_pnext;
    logic [CNT_W-1:0]  req_total;
    logic [1:0]        req_words;
    logic              req_illegal;
    logic              exe_cycle, exe_mem, exe_store;
    logic [AW-1:0]     src_val;

    assign req_op = mv_op_e'(req_op_i);

    dmove_agen #(.OFF_W(OFF_W)) u_agen_req (
        .op(req_op), .offset(req_imm_i[OFF_W-1:0]), .base_hi(st_q.rf[SEL_BASE][AW-1:OFF_W]),
        .ptr_val(st_q.rf[req_ptr_i]), .stepj(st_q.rf[SEL_STEPJ]), .pmod(req_pmod_i),
        .addr(req_addr), .ptr_next(req_pnext)
    );

    dmove_agen #(.OFF_W(OFF_W)) u_agen_exe (
        .op(st_q.op), .offset(st_q.imm[OFF_W-1:0]), .base_hi(st_q.rf[SEL_BASE][AW-1:OFF_W]),
        .ptr_val(st_q.rf[st_q.ptr]), .stepj(st_q.rf[SEL_STEPJ]), .pmod(st_q.pmod),
        .addr(exe_addr), .ptr_next(exe_pnext)
    );

    dmove_cost #(.WAIT_W(WAIT_W), .BANK_W(BANK_W), .EXT_W(EXT_W), .CNT_W(CNT_W)) u_cost (
        .op(req_op), .dst(req_dst_i), .from_cache(req_cache_i), .pc_ext(pc_ext_i),
        .pc_bank(pc_bank_i), .waits(wait_cnt_i), .addr_top(req_addr[AW-1:AW-EXT_W]),
        .addr_bank(req_addr[BANK_LSB+BANK_W-1:BANK_LSB]),
        .total(req_total), .words(req_words), .illegal(req_illegal)
    );

    // unused: req_pnext (cost only needs the access address)
    logic unused_ok;
    assign unused_ok = ^req_pnext;

    always_comb begin
        st_d      = st_q;
        exe_cycle = (st_q.cnt == CNT_W'(1));
        exe_mem   = (st_q.op == OP_LD_IND) || (st_q.op == OP_ST_IND) ||
                    (st_q.op == OP_LD_DIR) || (st_q.op == OP_ST_DIR);
        exe_store = (st_q.op == OP_ST_IND) || (st_q.op == OP_ST_DIR);
        src_val   = rd_ext(st_q.rf, st_q.src);

        if (st_q.cnt == '0) begin
            if (req_valid_i) begin
                st_d.cnt     = req_total;
                st_d.total   = req_total;
                st_d.words   = req_words;
                st_d.illegal = req_illegal;
                st_d.op      = req_op;
                st_d.dst     = req_dst_i;
                st_d.src     = req_src_i;
                st_d.ptr     = req_ptr_i;
                st_d.pmod    = req_pmod_i;
                st_d.imm     = req_imm_i;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end

        if (exe_cycle && !st_q.illegal) begin
            if (st_q.op == OP_LD_IND || st_q.op == OP_ST_IND)
                st_d.rf[st_q.ptr] = exe_pnext;
            if (int'(st_q.dst) < NREG) begin
                case (st_q.op)
                    OP_RR:     st_d.rf[st_q.dst] = wr_fmt(st_q.dst, src_val);
                    OP_LIMM:   st_d.rf[st_q.dst] = wr_fmt(st_q.dst, st_q.imm);
                    OP_SIMM:   st_d.rf[st_q.dst] = {7'b0, st_q.imm[8:0]};
                    OP_LD_IND,
                    OP_LD_DIR: st_d.rf[st_q.dst] = wr_fmt(st_q.dst, mem_rdata_i);
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready_o = (st_q.cnt == '0);
    assign done_o      = exe_cycle;
    assign cycles_o    = st_q.total;
    assign words_o     = st_q.words;
    assign illegal_o   = exe_cycle && st_q.illegal;
    assign bad_read_o  = exe_cycle && !st_q.illegal && (st_q.src == SEL_WO) &&
                         ((st_q.op == OP_RR) || exe_store);
    assign mem_req_o   = exe_cycle && !st_q.illegal && exe_mem;
    assign mem_we_o    = mem_req_o && exe_store;
    assign mem_addr_o  = exe_addr;
    assign mem_wdata_o = src_val;
endmodule

// File: rtl/dmove_chk.sv
module dmove_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic [2:0]  req_op_i,
    input logic        pc_ext_i,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [15:0] mem_wdata_o,
    input logic        done_o,
    input logic        illegal_o,
    input logic        bad_read_o
);
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    a_r11_mem_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> done_o);

    a_r6_illegal_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !mem_req_o);

    a_r10_wo_store_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_read_o && mem_we_o) |-> (mem_wdata_o == 16'h0));

    a_r5_simm_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_op_i == 3'd2 && !pc_ext_i) |=> done_o);
endmodule

bind dmove_unit dmove_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .pc_ext_i(pc_ext_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .done_o(done_o), .illegal_o(illegal_o), .bad_read_o(bad_read_o)
);

// File: tb/dmove_unit_bench.sv
module dmove_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [2:0]  req_op_i = '0;
    logic [3:0]  req_dst_i = '0, req_src_i = '0;
    logic [15:0] req_imm_i = '0;
    logic [1:0]  req_ptr_i = '0, req_pmod_i = '0;
    logic        req_cache_i = 1'b0, pc_ext_i = 1'b0;
    logic [1:0]  pc_bank_i = 2'd3;
    logic [3:0]  wait_cnt_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        done_o;
    logic [5:0]  cycles_o;
    logic [1:0]  words_o;
    logic        illegal_o, bad_read_o;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] bmem [256];
    logic [15:0] rr [10];

    dmove_unit u_dmove_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_rdata_i = bmem[mem_addr_o[7:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_o && mem_we_o) bmem[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rdv(input int sel);
        case (sel)
            6: return {{8{rr[6][7]}}, rr[6][7:0]};
            7: return {10'b0, rr[7][5:0]};
            8: return 16'h0;
            default: return rr[sel];
        endcase
    endfunction

    function automatic logic [15:0] fmtv(input int sel, input logic [15:0] v);
        case (sel)
            6: return {8'b0, v[7:0]};
            7: return {10'b0, v[5:0]};
            default: return v;
        endcase
    endfunction

    task automatic mv(input int op, input int dst, input int src, input logic [15:0] imm,
                      input int ptr, input int pm, input bit cache, input bit pcx,
                      input int pcb, input int ws, input string tag);
        logic [15:0] addr, ld;
        bit ismem, ill, isst, badr;
        int n, k;
        ismem = (op >= 3 && op <= 6);
        isst  = (op == 4 || op == 6);
        addr  = (op == 5 || op == 6) ? {rr[5][15:5], imm[4:0]} : rr[ptr];
        ill   = (op == 1 && cache) || (op == 2 && dst > 4);
        n     = (op == 2) ? 1 : 2;
        if (pcx || (ismem && addr[15:14] == 2'b11)) n += ws;
        if (ismem && !pcx && addr[15:14] != 2'b11 && int'(addr[11:10]) == pcb) n += 1;
        if (ill) n = 1;
        badr  = !ill && (op == 0 || isst) && src == 8;
        ld    = bmem[addr[7:0]];

        @(negedge clk);
        chk(req_ready_o, {tag, " R1 ready"}, req_ready_o, 1);
        req_valid_i = 1; req_op_i = 3'(op); req_dst_i = 4'(dst); req_src_i = 4'(src);
        req_imm_i = imm; req_ptr_i = 2'(ptr); req_pmod_i = 2'(pm); req_cache_i = cache;
        pc_ext_i = pcx; pc_bank_i = 2'(pcb); wait_cnt_i = 4'(ws);
        @(negedge clk);
        req_valid_i = 0;
        k = 1;
        while (!done_o && k < 40) begin
            chk(!mem_req_o, {tag, " R11 idle mem"}, mem_req_o, 0);
            @(negedge clk);
            k++;
        end
        chk(k == n, {tag, " R1/R2/R3 done cycle"}, k, n);
        chk(int'(cycles_o) == n, {tag, " R2/R3 cycles_o"}, cycles_o, n);
        chk(int'(words_o) == ((op == 1) ? 2 : 1), {tag, " R4 words"}, words_o, (op == 1) ? 2 : 1);
        chk(illegal_o == ill, {tag, " R6 illegal"}, illegal_o, ill);
        chk(bad_read_o == badr, {tag, " R10 bad_read"}, bad_read_o, badr);
        chk(mem_req_o == (ismem && !ill), {tag, " R11 mem_req"}, mem_req_o, ismem && !ill);
        if (ismem && !ill) begin
            chk(mem_addr_o == addr, {tag, " R7/R8 addr"}, mem_addr_o, addr);
            chk(mem_we_o == isst, {tag, " R11 we"}, mem_we_o, isst);
            if (isst) chk(mem_wdata_o == rdv(src), {tag, " R9/R10 wdata"}, mem_wdata_o, rdv(src));
        end
        if (!ill) begin
            if (op == 3 || op == 4) begin
                case (pm)
                    1: rr[ptr] = rr[ptr] + 1;
                    2: rr[ptr] = rr[ptr] - 1;
                    3: rr[ptr] = rr[ptr] + rr[4];
                    default: ;
                endcase
            end
            case (op)
                0: rr[dst] = fmtv(dst, rdv(src));
                1: rr[dst] = fmtv(dst, imm);
                2: rr[dst] = {7'b0, imm[8:0]};
                3, 5: rr[dst] = fmtv(dst, ld);
                default: ;
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 16'h0101 + 7);
        for (int i = 0; i < 10; i++) rr[i] = 16'h0;
        #(CLK_PERIOD * 2 + 1);
        chk(req_ready_o == 1 && done_o == 0 && mem_req_o == 0, "reset R1/R11", done_o, 0);
        rst_n = 1;
        // R1 R4 long immediates
        mv(1, 0, 0, 16'h0100, 0, 0, 0, 0, 3, 0, "limm ptr0");
        mv(1, 5, 0, 16'hABCD, 0, 0, 0, 0, 3, 0, "limm base");
        mv(1, 4, 0, 16'h0004, 0, 0, 0, 0, 3, 0, "limm stepj");
        // R5 short immediate, upper bits dropped
        mv(2, 1, 0, 16'hFFFF, 0, 0, 1, 0, 3, 0, "simm ptr1");
        mv(4, 0, 1, 16'h0, 2, 0, 0, 0, 3, 0, "R5 store ptr1");
        // R6 illegal requests, register unchanged
        mv(2, 9, 0, 16'h0055, 0, 0, 0, 0, 3, 0, "R6 simm acc");
        mv(1, 2, 0, 16'h0200, 0, 0, 1, 0, 3, 0, "R6 limm cache");
        mv(4, 0, 2, 16'h0, 0, 0, 0, 0, 3, 0, "R6 acc/ptr2 check");
        mv(4, 0, 9, 16'h0, 0, 0, 0, 0, 3, 0, "R6 acc check");
        // R9 extension
        mv(1, 9, 0, 16'h12F0, 0, 0, 0, 0, 3, 0, "limm acc");
        mv(0, 6, 9, 16'h0, 0, 0, 0, 0, 3, 0, "R9 copy to signed");
        mv(6, 0, 6, 16'h0003, 0, 0, 0, 0, 3, 0, "R9 R7 store signed direct");
        mv(0, 7, 9, 16'h0, 0, 0, 0, 0, 3, 0, "R9 copy to unsigned");
        mv(6, 0, 7, 16'h001F, 0, 0, 0, 0, 3, 0, "R9 store unsigned direct");
        // R10 write-only
        mv(1, 8, 0, 16'h5555, 0, 0, 0, 0, 3, 0, "limm wo");
        mv(4, 0, 8, 16'h0, 0, 0, 0, 0, 3, 0, "R10 store wo");
        mv(0, 9, 8, 16'h0, 0, 0, 0, 0, 3, 0, "R10 copy wo");
        mv(4, 0, 9, 16'h0, 0, 0, 0, 0, 3, 0, "R10 acc after");
        // R8 post-modification
        mv(4, 0, 9, 16'h0, 0, 1, 0, 0, 3, 0, "R8 inc");
        mv(4, 0, 9, 16'h0, 0, 3, 0, 0, 3, 0, "R8 addj");
        mv(4, 0, 9, 16'h0, 0, 2, 0, 0, 3, 0, "R8 dec");
        mv(3, 9, 0, 16'h0, 0, 0, 0, 0, 3, 0, "R8 R11 load ind");
        mv(5, 3, 0, 16'h0011, 0, 0, 0, 0, 3, 0, "R7 load dir");
        mv(4, 0, 3, 16'h0, 0, 0, 0, 0, 3, 0, "R7 check ptr3");
        // R2 wait states, R3 bank conflict
        mv(0, 9, 5, 16'h0, 0, 0, 0, 1, 0, 3, "R2 pc ext");
        mv(2, 2, 0, 16'h0011, 0, 0, 0, 1, 0, 5, "R2 R5 simm ext");
        mv(1, 3, 0, 16'hC010, 0, 0, 0, 0, 3, 0, "limm ptr3 ext");
        mv(4, 0, 9, 16'h0, 3, 0, 0, 0, 3, 2, "R2 data ext");
        mv(4, 0, 9, 16'h0, 0, 0, 0, 0, 0, 2, "R3 same bank");
        mv(3, 9, 0, 16'h0, 0, 0, 0, 0, 1, 2, "R3 other bank");
        mv(5, 9, 0, 16'h0002, 0, 0, 0, 0, 2, 0, "R3 direct bank");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule